// File: doc/BRIEF.md
# Dual-Clock FIFO with Rewind

A first-in first-out buffer whose write side and read side run on separate clocks. Words enter on `wclk` when `wen` is high and leave on `rclk` when `ren` is high. Each side keeps a binary pointer with one wrap bit. The pointer crosses to the other clock as a Gray code through a two-flop synchronizer. Each side works out its own occupancy from the two pointers. From that occupancy it drives its flags: empty, half-full and almost-empty on the read side, full and almost-full on the write side.

Two static straps select the read behaviour. With `fwft_mode` low the buffer runs in standard mode: every word needs `ren` on a read-clock edge, and `empty` means that no stored word is left. With `fwft_mode` high the head word moves to `dout` by itself, and `empty` means that `dout` holds no valid word. The rewind input `rewind`, sampled on `rclk`, moves the read pointer back to array location zero so that everything written since reset can be read again. Writes keep appending at the existing write pointer. The `zero_lat` strap selects between two kinds of rewind. A normal-latency rewind passes through a one-cycle setup state. A zero-latency rewind places word 0 on `dout` at the rewind edge itself.

The read controller has two states. RUN is the working state. SETUP is the single cycle that follows a normal-latency rewind. There are two transitions. REWIND goes from RUN to SETUP when `rewind` is high and `zero_lat` is low. RESUME goes from SETUP back to RUN with no condition. A zero-latency rewind stays in RUN. A rewind that arrives during SETUP is ignored.

Top module: `fifo_rt`

## Requirements
- R1: During and after reset, `dout` is 0. `empty` and `almost_empty` are 1. `half_full`, `almost_full` and `full` are 0.
- R2: In standard mode, a word appears on `dout` just after each `rclk` edge that has `ren` high and `empty` low. Words come out in the order in which they were written.
- R3: In FWFT mode, the oldest unread word is on `dout` with `empty` low, without any `ren`. An `rclk` edge with `ren` high replaces it with the next word in write order.
- R4: `full` is 1 when the write side counts DEPTH stored words. A write attempted while `full` is 1 stores nothing and does not move the write pointer.
- R5: In standard mode, `ren` while `empty` is 1 leaves `dout` unchanged and does not move the read pointer.
- R6: Normal-latency rewind, standard mode: on the `rclk` edge that samples `rewind` high, the controller enters SETUP. `empty` reads 1 for exactly that one cycle. The following reads return words starting at location 0, and each needs `ren`.
- R7: Normal-latency rewind, FWFT mode: `empty` reads 1 after the rewind edge. On the next edge word 0 is on `dout` and `empty` is 0, with no `ren`.
- R8: Zero-latency rewind: word 0 is on `dout` just after the rewind edge. In standard mode the next `ren` returns word 1. In FWFT mode `empty` stays 0 and `ren` moves on to word 1.
- R9: After a rewind, occupancy is recomputed as the write pointer minus location zero. Words written after the rewind are read after all earlier words. The buffer drains to `empty` = 1.
- R10: On a rewind, `half_full` takes its new value on the rewind edge itself. `almost_empty` takes its new value on the next `rclk` edge.
- R11: `almost_empty` is the registered result of read-side count <= AE_OFF. `half_full` is 1 while read-side count >= DEPTH/2. `almost_full` is 1 while write-side count >= DEPTH-AF_OFF. In FWFT mode the read-side count leaves out the word held on `dout`.
- R12: `dout` holds its value on every `rclk` edge that neither reads nor rewinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| w_rst | input | 1 | Synchronous reset of the write side, active high |
| wen | input | 1 | Write enable |
| din | input | DATA_W | Write data |
| rclk | input | 1 | Read clock |
| r_rst | input | 1 | Synchronous reset of the read side, active high |
| ren | input | 1 | Read enable |
| rewind | input | 1 | Rewind request, sampled on `rclk` |
| fwft_mode | input | 1 | Strap: 1 selects FWFT mode, 0 selects standard mode |
| zero_lat | input | 1 | Strap: 1 selects zero-latency rewind |
| dout | output | DATA_W | Read data register |
| empty | output | 1 | Nothing to read (standard mode) or no valid word on `dout` (FWFT mode); also 1 during SETUP |
| almost_empty | output | 1 | Read-side count at or below AE_OFF |
| half_full | output | 1 | Read-side count at or above DEPTH/2 |
| almost_full | output | 1 | Write-side count at or above DEPTH-AF_OFF |
| full | output | 1 | Write side holds DEPTH words |

## Verification
The bench builds the block with ADDR_W = 4, which gives a depth of 16, and sets both AE_OFF and AF_OFF to 2. At that depth the full boundary, the half-full boundary and a complete fill and drain take only a few dozen cycles. Every rewind can also stay inside the valid window of at least two and at most depth minus two words. With an almost-empty offset of 2, a rewind taken when one word remains moves `almost_empty` from 1 to 0. This makes it possible to observe the one-edge lag of that flag alongside the immediate change of `half_full`. Random word counts are applied under all four combinations of the two straps.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

    typedef enum logic [0:0] {
        RS_RUN   = 1'b0,
        RS_SETUP = 1'b1
    } rd_state_e;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        for (int i = 0; i < 32; i++) begin
            b[i] = ^(g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/fifo_rt_sync.sv
module fifo_rt_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/fifo_rt_wr.sv
module fifo_rt_wr import fifo_rt_pkg::*; #(
    parameter int ADDR_W = 4,
    parameter int AF_OFF = 2
) (
    input  logic              wclk,
    input  logic              w_rst,
    input  logic              wen,
    input  logic [ADDR_W:0]   rgray_s,
    output logic [ADDR_W-1:0] waddr,
    output logic              we,
    output logic [ADDR_W:0]   wgray,
    output logic              full,
    output logic              almost_full
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] FULL_LIM = PW'(DEPTH);
    localparam logic [PW-1:0] AF_LIM   = PW'(DEPTH - AF_OFF);

    logic [PW-1:0] wptr, rbin, wcount, wptr_n;

    assign rbin        = PW'(gray2bin(32'(rgray_s)));
    assign wcount      = wptr - rbin;
    assign full        = (wcount == FULL_LIM);
    assign almost_full = (wcount >= AF_LIM);
    assign we          = wen && !full;
    assign waddr       = wptr[ADDR_W-1:0];
    assign wptr_n      = wptr + PW'(we);

    always_ff @(posedge wclk) begin
        if (w_rst) begin
            wptr  <= '0;
            wgray <= '0;
        end else begin
            wptr  <= wptr_n;
            wgray <= PW'(bin2gray(32'(wptr_n)));
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge wclk) disable iff (w_rst)
        (wen && full) |=> (wptr == $past(wptr)));

    // R11
    full_af_chk: assert property (@(posedge wclk) disable iff (w_rst)
        full |-> almost_full);
endmodule

// File: rtl/fifo_rt_rd.sv
module fifo_rt_rd import fifo_rt_pkg::*; #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4,
    parameter int AE_OFF = 2
) (
    input  logic              rclk,
    input  logic              r_rst,
    input  logic              ren,
    input  logic              rewind,
    input  logic              fwft_mode,
    input  logic              zero_lat,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              almost_empty,
    output logic              half_full
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] AE_LIM   = PW'(AE_OFF);
    localparam logic [PW-1:0] HALF_LIM = PW'(DEPTH / 2);

    rd_state_e         state, state_n;
    logic [PW-1:0]     rptr, rptr_n, wbin, rcount;
    logic [DATA_W-1:0] dout_n;
    logic              valid, valid_n, load, rew_go, rew_zero, mem_empty, ae_q;

    assign wbin      = PW'(gray2bin(32'(wgray_s)));
    assign rcount    = wbin - rptr;
    assign mem_empty = (rcount == '0);
    assign rew_go    = (state == RS_RUN) && rewind;
    assign rew_zero  = rew_go && zero_lat && (wbin != '0);
    assign raddr     = rew_zero ? '0 : rptr[ADDR_W-1:0];

    // state register
    always_ff @(posedge rclk) begin
        if (r_rst) state <= RS_RUN;
        else       state <= state_n;
    end

    // transitions: REWIND (RUN->SETUP), RESUME (SETUP->RUN)
    always_comb begin
        state_n = state;
        unique case (state)
            RS_RUN:   if (rewind && !zero_lat) state_n = RS_SETUP;
            RS_SETUP: state_n = RS_RUN;
        endcase
    end

    // output and pointer next values
    always_comb begin
        rptr_n  = rptr;
        dout_n  = dout;
        valid_n = valid;
        load    = 1'b0;
        unique case (state)
            RS_RUN: begin
                if (rew_go) begin
                    if (rew_zero) begin
                        load = 1'b1;
                    end else begin
                        rptr_n  = '0;
                        valid_n = 1'b0;
                    end
                end else if (fwft_mode) begin
                    if (!mem_empty && (!valid || ren)) load = 1'b1;
                    else if (ren)                       valid_n = 1'b0;
                end else if (ren && !mem_empty) begin
                    load = 1'b1;
                end
            end
            RS_SETUP: begin
                if (fwft_mode && !mem_empty) load = 1'b1;
            end
        endcase
        if (load) begin
            dout_n  = rdata;
            rptr_n  = rew_zero ? PW'(1) : rptr + PW'(1);
            valid_n = 1'b1;
        end
    end

    always_ff @(posedge rclk) begin
        if (r_rst) begin
            rptr  <= '0;
            rgray <= '0;
            dout  <= '0;
            valid <= 1'b0;
            ae_q  <= 1'b1;
        end else begin
            rptr  <= rptr_n;
            rgray <= PW'(bin2gray(32'(rptr_n)));
            dout  <= dout_n;
            valid <= valid_n;
            ae_q  <= (rcount <= AE_LIM);
        end
    end

    assign empty        = (state == RS_SETUP) || (fwft_mode ? !valid : mem_empty);
    assign almost_empty = ae_q;
    assign half_full    = (rcount >= HALF_LIM);

    // R6
    rewind_setup_chk: assert property (@(posedge rclk) disable iff (r_rst)
        (state == RS_RUN && rewind && !zero_lat) |=> (empty && state == RS_SETUP));

    // R6
    setup_once_chk: assert property (@(posedge rclk) disable iff (r_rst)
        (state == RS_SETUP) |=> (state == RS_RUN));

    // R5
    empty_read_chk: assert property (@(posedge rclk) disable iff (r_rst)
        (state == RS_RUN && !fwft_mode && ren && empty && !rewind) |=> $stable(dout));

    // R12
    hold_dout_chk: assert property (@(posedge rclk) disable iff (r_rst)
        (state == RS_RUN && !fwft_mode && !ren && !rewind) |=> $stable(dout));

    // R8
    zero_rewind_chk: assert property (@(posedge rclk) disable iff (r_rst)
        (state == RS_RUN && rewind && zero_lat && wbin != '0) |=> (rptr == PW'(1)));
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4,
    parameter int AE_OFF = 2,
    parameter int AF_OFF = 2
) (
    input  logic              wclk,
    input  logic              w_rst,
    input  logic              wen,
    input  logic [DATA_W-1:0] din,
    input  logic              rclk,
    input  logic              r_rst,
    input  logic              ren,
    input  logic              rewind,
    input  logic              fwft_mode,
    input  logic              zero_lat,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              almost_empty,
    output logic              half_full,
    output logic              almost_full,
    output logic              full
);
    localparam int PW = ADDR_W + 1;

    logic [ADDR_W-1:0] waddr, raddr;
    logic [DATA_W-1:0] rdata;
    logic              we;
    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;

    fifo_rt_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(rdata)
    );

    fifo_rt_wr #(.ADDR_W(ADDR_W), .AF_OFF(AF_OFF)) u_wr (
        .wclk(wclk), .w_rst(w_rst), .wen(wen), .rgray_s(rgray_s),
        .waddr(waddr), .we(we), .wgray(wgray),
        .full(full), .almost_full(almost_full)
    );

    fifo_rt_sync #(.W(PW)) u_w2r (
        .clk(rclk), .rst(r_rst), .d(wgray), .q(wgray_s)
    );

    fifo_rt_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst(w_rst), .d(rgray), .q(rgray_s)
    );

    fifo_rt_rd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .AE_OFF(AE_OFF)) u_rd (
        .rclk(rclk), .r_rst(r_rst), .ren(ren), .rewind(rewind),
        .fwft_mode(fwft_mode), .zero_lat(zero_lat), .wgray_s(wgray_s),
        .rdata(rdata), .raddr(raddr), .rgray(rgray), .dout(dout),
        .empty(empty), .almost_empty(almost_empty), .half_full(half_full)
    );
endmodule

// File: tb/fifo_rt_bench.sv
module fifo_rt_bench;
    localparam int DW    = 18;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int AE    = 2;
    localparam int AF    = 2;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          w_rst = 1'b1, r_rst = 1'b1;
    logic          wen = 1'b0, ren = 1'b0, rewind = 1'b0;
    logic          fwft = 1'b0, zl = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          empty, almost_empty, half_full, almost_full, full;

    int n_tests = 0;
    int n_fail  = 0;
    logic [DW-1:0] expd [2*DEPTH];

    always #10 wclk = ~wclk;
    initial begin
        #7;
        forever #10 rclk = ~rclk;
    end

    fifo_rt #(.DATA_W(DW), .ADDR_W(AW), .AE_OFF(AE), .AF_OFF(AF)) u_fifo_rt (
        .wclk(wclk), .w_rst(w_rst), .wen(wen), .din(din),
        .rclk(rclk), .r_rst(r_rst), .ren(ren), .rewind(rewind),
        .fwft_mode(fwft), .zero_lat(zl), .dout(dout), .empty(empty),
        .almost_empty(almost_empty), .half_full(half_full),
        .almost_full(almost_full), .full(full)
    );

    function automatic logic [31:0] exp_ae(input int c);
        return {31'd0, c <= AE};
    endfunction
    function automatic logic [31:0] exp_hf(input int c);
        return {31'd0, c >= DEPTH / 2};
    endfunction
    function automatic logic [31:0] exp_af(input int c);
        return {31'd0, c >= DEPTH - AF};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_r(input int c);
        repeat (c) @(posedge rclk);
        #1;
    endtask

    task automatic apply_reset(input logic f, input logic z);
        fwft = f; zl = z;
        w_rst = 1'b1; r_rst = 1'b1;
        wen = 1'b0; ren = 1'b0; rewind = 1'b0;
        repeat (3) @(posedge wclk);
        repeat (3) @(posedge rclk);
        #1;
        w_rst = 1'b0; r_rst = 1'b0;
        wait_r(4);
        check("R1", "dout", dout, 0);
        check("R1", "empty", empty, 1);
        check("R1", "almost_empty", almost_empty, 1);
        check("R1", "half_full", half_full, 0);
        check("R1", "almost_full", almost_full, 0);
        check("R1", "full", full, 0);
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(posedge wclk);
        #1 wen = 1'b1; din = d;
        @(posedge wclk);
        #1 wen = 1'b0;
    endtask

    task automatic pulse_ren();
        @(posedge rclk);
        #1 ren = 1'b1;
        @(posedge rclk);
        #1 ren = 1'b0;
    endtask

    task automatic pop_expect(input logic [DW-1:0] e, input string req);
        if (fwft) begin
            check(req, "ready", empty, 0);
            check(req, "head", dout, e);
            pulse_ren();
        end else begin
            pulse_ren();
            check(req, "data", dout, e);
        end
    endtask

    task automatic round(input logic f, input logic z, input int n, input int k, input int m);
        int start;
        apply_reset(f, z);
        for (int i = 0; i < n; i++) begin
            expd[i] = DW'($urandom);
            push(expd[i]);
        end
        wait_r(6);
        if (!f) begin
            check("R11", "almost_empty", almost_empty, exp_ae(n));
            check("R11", "half_full", half_full, exp_hf(n));
            check("R11", "almost_full", almost_full, exp_af(n));
        end
        for (int i = 0; i < k; i++) pop_expect(expd[i], f ? "R3" : "R2");
        wait_r(6);
        check("R12", "hold", dout, f ? expd[k] : expd[k-1]);
        if (!f) check("R11", "half_full", half_full, exp_hf(n - k));
        // rewind pulse; afterwards the rewind edge has passed
        @(posedge rclk);
        #1 rewind = 1'b1;
        @(posedge rclk);
        #1 rewind = 1'b0;
        if (z) begin
            check("R8", "word0", dout, expd[0]);
            if (f) check("R8", "ready", empty, 0);
        end else begin
            check(f ? "R7" : "R6", "setup flag", empty, 1);
            if (!f) begin
                check("R10", "hf at rewind edge", half_full, exp_hf(n));
                check("R10", "ae held", almost_empty, exp_ae(n - k));
            end
            @(posedge rclk);
            #1;
            check(f ? "R7" : "R6", "setup done", empty, 0);
            if (f)  check("R7", "word0", dout, expd[0]);
            if (!f) check("R10", "ae next edge", almost_empty, exp_ae(n));
        end
        wait_r(2);
        for (int i = 0; i < m; i++) begin
            expd[n+i] = DW'($urandom);
            push(expd[n+i]);
        end
        wait_r(6);
        start = (z && !f) ? 1 : 0;
        for (int i = start; i < n + m; i++) pop_expect(expd[i], "R9");
        wait_r(6);
        check("R9", "drained", empty, 1);
    endtask

    initial begin
        int unsigned seed;
        logic [DW-1:0] x;
        seed = $urandom(32'd4242);

        // R5: read while empty
        apply_reset(1'b0, 1'b0);
        pulse_ren();
        check("R5", "dout after empty read", dout, 0);
        check("R5", "empty", empty, 1);
        x = DW'($urandom);
        push(x);
        wait_r(6);
        pop_expect(x, "R5");
        pulse_ren();
        check("R5", "dout held", dout, x);

        // R4: overfill
        apply_reset(1'b0, 1'b0);
        for (int i = 0; i < DEPTH + 2; i++) begin
            expd[i] = DW'($urandom);
            push(expd[i]);
        end
        check("R4", "full", full, 1);
        check("R11", "almost_full at full", almost_full, 1);
        wait_r(6);
        for (int i = 0; i < DEPTH; i++) pop_expect(expd[i], "R4");
        wait_r(6);
        check("R4", "empty after drain", empty, 1);
        check("R4", "full cleared", full, 0);

        // R10 directed: one word left, rewind to ten
        round(1'b0, 1'b0, 10, 9, 1);

        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 3; r++) begin
                int n, k, m;
                n = int'($urandom_range(DEPTH - 2, 4));
                k = int'($urandom_range(n - 1, 2));
                m = int'($urandom_range(DEPTH - n, 1));
                round(c[1], c[0], n, k, m);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wclk);
        n_tests++;
        n_fail++;
        $display("FAIL all watchdog: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule